// File: doc/BRIEF.md
# AXI-Lite Register Bank with Per-Word Access Modes

This block is an AXI-Lite slave that holds a fixed array of 32-bit words. Each word has its own access mode, chosen by parameter: read-only, write-only, read-write, write-1-to-clear and self-clearing write-1-to-set. A wider field is several adjacent words that share one mode. The host reaches each word at byte offset 4 × index, one word per transaction.

Internal logic sees every stored word at once on a flat output. It can overwrite any word through an owner write port, and that write ignores the host mode rules. For each word there is a one-cycle pulse output that marks an accepted host write. Logic that watches it, such as a start trigger or a status clear, sees the updated word value in the same cycle as the pulse.

Accesses that are misaligned, outside the mapped range or forbidden by the mode still complete. They return SLVERR, read back zero and leave storage untouched.

Top module: `axil_regbank`

## Requirements
- R1: After synchronous reset, every stored word is 0, `s_bvalid` and `s_rvalid` are low, and `wr_pulse` is all zero.
- R2: Default map: 8 words at byte offsets 0x00 to 0x1C. The modes are, for word 0 to word 7: read-write, read-write (words 0 and 1 form a two-word field), read-only, write-only, write-1-to-clear, write-1-to-set, read-write, read-only. A host write to a read-write or write-only word replaces only the bytes enabled by `s_wstrb`. A host read of a read-write word returns the stored value with OKAY (2'b00).
- R3: A host write to a read-only word and a host read of a write-only word complete with SLVERR (2'b10). A rejected read returns data 0, and a rejected write leaves storage unchanged.
- R4: An address with bits [1:0] nonzero, or at or above NUM_WORDS × 4, is an error. Reads return SLVERR with data 0. Writes return SLVERR and change nothing.
- R5: A host write to a write-1-to-clear word with value v and byte mask m leaves the word as old AND NOT (v AND m).
- R6: A host write to a write-1-to-set word ORs (v AND m) into the word. The new value shows on `own_words` in the same cycle as the pulse, and the word returns to 0 in the next cycle. Later host reads return 0.
- R7: `wr_pulse[i]` is high for exactly one cycle per OKAY host write to word i. That cycle is the first cycle in which `s_bvalid` is high, and the stored value already includes the write (after clear masking). Erroneous writes produce no pulse.
- R8: An owner write stores `own_wdata` into word `own_idx` unchanged, whatever the mode. When a host write hits the same word in the same cycle, the owner value wins.
- R9: AW and W may arrive in either order or together. Each write gives exactly one B response and each read gives one R beat. `s_bvalid` and `s_rvalid`, together with their data and response, hold until accepted. No new address is accepted while a response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | ADDR_W | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte enables |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| own_we | input | 1 | Owner write enable |
| own_idx | input | IDX_W | Owner word index |
| own_wdata | input | DATA_W | Owner write value |
| own_words | output | NUM_WORDS×DATA_W | All stored words, word i at bits [32i+31:32i] |
| wr_pulse | output | NUM_WORDS | One-cycle host write notification per word |

## Verification
The bench uses the default parameters: 8 words, 8-bit addresses and the default mode vector. With these values all five modes are present, and so is a two-word field. The mapped range ends at 0x20, well inside the 256-byte address space, so many out-of-range aligned addresses can be reached as well as misaligned ones. Random traffic with random strobes and channel ordering runs against a bench model, together with directed checks for the collision, back-pressure and self-clear timing.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  typedef enum logic [2:0] {
    ACC_RO  = 3'd0,
    ACC_WO  = 3'd1,
    ACC_RW  = 3'd2,
    ACC_W1C = 3'd3,
    ACC_W1S = 3'd4
  } acc_mode_e;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
endpackage

// File: rtl/regbank_word.sv
module regbank_word
  import regbank_pkg::*;
#(
  parameter int        DATA_W = 32,
  parameter acc_mode_e MODE   = ACC_RW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_we,
  input  logic [DATA_W-1:0]   host_data,
  input  logic [DATA_W/8-1:0] host_strb,
  input  logic                own_we,
  input  logic [DATA_W-1:0]   own_data,
  output logic [DATA_W-1:0]   q,
  output logic                pulse
);
  localparam int STRB_W = DATA_W / 8;

  logic [DATA_W-1:0] bmask;
  logic [DATA_W-1:0] set_bits;

  for (genvar b = 0; b < STRB_W; b++) begin : g_mask
    assign bmask[8*b +: 8] = {8{host_strb[b]}};
  end
  assign set_bits = host_data & bmask;

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= host_we;
      if (own_we) begin
        q <= own_data;
      end else if (host_we) begin
        if (MODE == ACC_W1C)      q <= q & ~set_bits;
        else if (MODE == ACC_W1S) q <= q | set_bits;
        else                      q <= (q & ~bmask) | set_bits;
      end else if (MODE == ACC_W1S && pulse) begin
        q <= '0;
      end
    end
  end

  AST_OWN_WINS: assert property (@(posedge clk) disable iff (rst)
    own_we |=> q == $past(own_data)); // R8

  if (MODE == ACC_W1C) begin : g_w1c_chk
    AST_W1C_NEVER_SETS: assert property (@(posedge clk) disable iff (rst)
      (host_we && !own_we) |=> (q & ~$past(q)) == '0); // R5
  end
  if (MODE == ACC_W1S) begin : g_w1s_chk
    AST_W1S_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (pulse && !host_we && !own_we) |=> q == '0); // R6
  end
  if (MODE == ACC_RO) begin : g_ro_chk
    AST_RO_HOST_BLOCKED: assert property (@(posedge clk) disable iff (rst)
      !own_we |=> $stable(q)); // R3
  end
endmodule

// File: rtl/regbank_wr_path.sv
module regbank_wr_path
  import regbank_pkg::*;
#(
  parameter int                       ADDR_W     = 8,
  parameter int                       DATA_W     = 32,
  parameter int                       NUM_WORDS  = 8,
  parameter logic [3*NUM_WORDS-1:0]   WORD_MODES = '0,
  localparam int                      STRB_W     = DATA_W / 8,
  localparam int                      LSB        = $clog2(STRB_W),
  localparam int                      IDX_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  output logic              hw_we,
  output logic [IDX_W-1:0]  hw_idx,
  output logic [DATA_W-1:0] hw_data,
  output logic [STRB_W-1:0] hw_strb
);
  logic              aw_have, w_have, go, err, in_range;
  logic [ADDR_W-1:0] aw_q, word_no;
  acc_mode_e         mode;

  assign awready  = !aw_have && !bvalid;
  assign wready   = !w_have && !bvalid;
  assign go       = aw_have && w_have && !bvalid;
  assign word_no  = aw_q >> LSB;
  assign in_range = 32'(word_no) < NUM_WORDS;
  assign hw_idx   = word_no[IDX_W-1:0];
  assign mode     = in_range ? acc_mode_e'(WORD_MODES[3*hw_idx +: 3]) : ACC_RW;
  assign err      = (aw_q[LSB-1:0] != '0) || !in_range || (mode == ACC_RO);
  assign hw_we    = go && !err;

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_have <= 1'b0;
      w_have  <= 1'b0;
      bvalid  <= 1'b0;
      bresp   <= RESP_OKAY;
      aw_q    <= '0;
      hw_data <= '0;
      hw_strb <= '0;
    end else begin
      if (awvalid && awready) begin
        aw_have <= 1'b1;
        aw_q    <= awaddr;
      end
      if (wvalid && wready) begin
        w_have  <= 1'b1;
        hw_data <= wdata;
        hw_strb <= wstrb;
      end
      if (go) begin
        aw_have <= 1'b0;
        w_have  <= 1'b0;
        bvalid  <= 1'b1;
        bresp   <= err ? RESP_SLVERR : RESP_OKAY;
      end else if (bvalid && bready) begin
        bvalid <= 1'b0;
      end
    end
  end

  AST_B_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bvalid && !bready) |=> (bvalid && $stable(bresp))); // R9
endmodule

// File: rtl/regbank_rd_path.sv
module regbank_rd_path
  import regbank_pkg::*;
#(
  parameter int                       ADDR_W     = 8,
  parameter int                       DATA_W     = 32,
  parameter int                       NUM_WORDS  = 8,
  parameter logic [3*NUM_WORDS-1:0]   WORD_MODES = '0,
  localparam int                      LSB        = $clog2(DATA_W / 8),
  localparam int                      IDX_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           araddr,
  input  logic                        arvalid,
  output logic                        arready,
  output logic [DATA_W-1:0]           rdata,
  output logic [1:0]                  rresp,
  output logic                        rvalid,
  input  logic                        rready,
  input  logic [NUM_WORDS*DATA_W-1:0] words
);
  logic [ADDR_W-1:0] word_no;
  logic [IDX_W-1:0]  idx;
  logic              in_range, err;
  acc_mode_e         mode;

  assign arready  = !rvalid;
  assign word_no  = araddr >> LSB;
  assign in_range = 32'(word_no) < NUM_WORDS;
  assign idx      = word_no[IDX_W-1:0];
  assign mode     = in_range ? acc_mode_e'(WORD_MODES[3*idx +: 3]) : ACC_RO;
  assign err      = (araddr[LSB-1:0] != '0) || !in_range || (mode == ACC_WO);

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
      rresp  <= RESP_OKAY;
    end else if (arvalid && arready) begin
      rvalid <= 1'b1;
      rdata  <= err ? '0 : words[idx*DATA_W +: DATA_W];
      rresp  <= err ? RESP_SLVERR : RESP_OKAY;
    end else if (rvalid && rready) begin
      rvalid <= 1'b0;
    end
  end

  AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rvalid && rresp == RESP_SLVERR) |-> rdata == '0); // R3
  AST_R_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rvalid && !rready) |=> (rvalid && $stable(rdata) && $stable(rresp))); // R9
endmodule

// File: rtl/axil_regbank.sv
module axil_regbank
  import regbank_pkg::*;
#(
  parameter int                     ADDR_W     = 8,
  parameter int                     DATA_W     = 32,
  parameter int                     NUM_WORDS  = 8,
  parameter logic [3*NUM_WORDS-1:0] WORD_MODES = {3'd0, 3'd2, 3'd4, 3'd3, 3'd1, 3'd0, 3'd2, 3'd2},
  localparam int                    STRB_W     = DATA_W / 8,
  localparam int                    IDX_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           s_awaddr,
  input  logic                        s_awvalid,
  output logic                        s_awready,
  input  logic [DATA_W-1:0]           s_wdata,
  input  logic [STRB_W-1:0]           s_wstrb,
  input  logic                        s_wvalid,
  output logic                        s_wready,
  output logic [1:0]                  s_bresp,
  output logic                        s_bvalid,
  input  logic                        s_bready,
  input  logic [ADDR_W-1:0]           s_araddr,
  input  logic                        s_arvalid,
  output logic                        s_arready,
  output logic [DATA_W-1:0]           s_rdata,
  output logic [1:0]                  s_rresp,
  output logic                        s_rvalid,
  input  logic                        s_rready,
  input  logic                        own_we,
  input  logic [IDX_W-1:0]            own_idx,
  input  logic [DATA_W-1:0]           own_wdata,
  output logic [NUM_WORDS*DATA_W-1:0] own_words,
  output logic [NUM_WORDS-1:0]        wr_pulse
);
  logic              hw_we;
  logic [IDX_W-1:0]  hw_idx;
  logic [DATA_W-1:0] hw_data;
  logic [STRB_W-1:0] hw_strb;

  regbank_wr_path #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .WORD_MODES(WORD_MODES)
  ) u_wr (
    .clk(clk), .rst(rst),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
    .hw_we(hw_we), .hw_idx(hw_idx), .hw_data(hw_data), .hw_strb(hw_strb)
  );

  regbank_rd_path #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .WORD_MODES(WORD_MODES)
  ) u_rd (
    .clk(clk), .rst(rst),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .words(own_words)
  );

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    regbank_word #(
      .DATA_W(DATA_W), .MODE(acc_mode_e'(WORD_MODES[3*i +: 3]))
    ) u_word (
      .clk(clk), .rst(rst),
      .host_we(hw_we && (hw_idx == IDX_W'(i))),
      .host_data(hw_data), .host_strb(hw_strb),
      .own_we(own_we && (own_idx == IDX_W'(i))),
      .own_data(own_wdata),
      .q(own_words[i*DATA_W +: DATA_W]),
      .pulse(wr_pulse[i])
    );
  end

  AST_PULSE_WITH_OKAY: assert property (@(posedge clk) disable iff (rst)
    (|wr_pulse) |-> (s_bvalid && s_bresp == RESP_OKAY)); // R7
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_pulse)); // R7
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (|wr_pulse) |=> !(|wr_pulse)); // R7
endmodule

// File: tb/axil_regbank_bench.sv
module axil_regbank_bench;
  localparam int NW = 8;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst;
  logic [AW-1:0]   s_awaddr = '0;
  logic            s_awvalid = 1'b0;
  logic            s_awready;
  logic [DW-1:0]   s_wdata = '0;
  logic [3:0]      s_wstrb = '0;
  logic            s_wvalid = 1'b0;
  logic            s_wready;
  logic [1:0]      s_bresp;
  logic            s_bvalid;
  logic            s_bready = 1'b1;
  logic [AW-1:0]   s_araddr = '0;
  logic            s_arvalid = 1'b0;
  logic            s_arready;
  logic [DW-1:0]   s_rdata;
  logic [1:0]      s_rresp;
  logic            s_rvalid;
  logic            s_rready = 1'b1;
  logic            own_we = 1'b0;
  logic [2:0]      own_idx = '0;
  logic [DW-1:0]   own_wdata = '0;
  logic [NW*DW-1:0] own_words;
  logic [NW-1:0]   wr_pulse;

  axil_regbank u_axil_regbank (
    .clk(clk), .rst(rst),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .own_we(own_we), .own_idx(own_idx), .own_wdata(own_wdata),
    .own_words(own_words), .wr_pulse(wr_pulse)
  );

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] model [NW];

  // Mode codes per R2: 0 RO, 1 WO, 2 RW, 3 W1C, 4 W1S
  function automatic int mode_of(int i);
    case (i)
      0, 1, 6: return 2;
      2, 7:    return 0;
      3:       return 1;
      4:       return 3;
      default: return 4;
    endcase
  endfunction

  function automatic logic [31:0] bmask(logic [3:0] s);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{s[b]}};
    return m;
  endfunction

  function automatic bit addr_bad(logic [AW-1:0] a);
    return (a[1:0] != 2'b00) || (a >= 8'(NW*4));
  endfunction

  function automatic logic [31:0] host_new(int md, logic [31:0] old, logic [31:0] d, logic [3:0] s);
    logic [31:0] m = bmask(s);
    case (md)
      3:       return old & ~(d & m);
      4:       return old | (d & m);
      default: return (old & ~m) | (d & m);
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    for (int i = 0; i < NW; i++)
      check(own_words[i*DW +: DW] == model[i], req, $sformatf("word %0d", i),
            own_words[i*DW +: DW], model[i]);
  endtask

  task automatic host_write(logic [AW-1:0] addr, logic [31:0] data, logic [3:0] strb,
                            int order, bit collide, logic [31:0] cdata, string req);
    int idx = int'(addr >> 2);
    bit err = addr_bad(addr) || (mode_of(idx) == 0);
    logic [31:0] nv = err ? 32'h0 : host_new(mode_of(idx), model[idx], data, strb);
    logic [1:0]  hold_resp;
    bit aw_done = 0, w_done = 0, a, b;
    s_awaddr = addr; s_wdata = data; s_wstrb = strb;
    s_awvalid = (order != 2);
    s_wvalid  = (order != 1);
    while (!(aw_done && w_done)) begin
      a = s_awvalid && s_awready;
      b = s_wvalid && s_wready;
      @(negedge clk);
      if (a) begin s_awvalid = 1'b0; aw_done = 1; end
      if (b) begin s_wvalid = 1'b0; w_done = 1; end
      if (!aw_done && !s_awvalid) s_awvalid = 1'b1;
      if (!w_done && !s_wvalid) s_wvalid = 1'b1;
    end
    if (collide) begin own_we = 1'b1; own_idx = idx[2:0]; own_wdata = cdata; end
    while (!s_bvalid) @(negedge clk);
    own_we = 1'b0;
    check(s_bresp == (err ? 2'b10 : 2'b00), req, "bresp", 32'(s_bresp), err ? 32'd2 : 32'd0);
    check(wr_pulse == (err ? 8'h0 : 8'(1 << idx)), "R7", "pulse at B", 32'(wr_pulse),
          err ? 32'h0 : 32'(1 << idx));
    if (!err) begin
      if (collide) begin
        check(own_words[idx*DW +: DW] == cdata, "R8", "owner wins", own_words[idx*DW +: DW], cdata);
        model[idx] = cdata;
      end else begin
        check(own_words[idx*DW +: DW] == nv, req, "value at pulse", own_words[idx*DW +: DW], nv);
        model[idx] = (mode_of(idx) == 4) ? 32'h0 : nv;
      end
    end
    if (!s_bready) begin
      hold_resp = s_bresp;
      repeat (3) @(negedge clk);
      check(s_bvalid && s_bresp == hold_resp, "R9", "B held", 32'(s_bvalid), 32'h1);
      check(!s_awready, "R9", "AW blocked while B pending", 32'(s_awready), 32'h0);
      s_bready = 1'b1;
    end
    @(negedge clk);
    check(wr_pulse == '0, "R7", "pulse one cycle", 32'(wr_pulse), 32'h0);
    if (!err && !collide && mode_of(idx) == 4)
      check(own_words[idx*DW +: DW] == 32'h0, "R6", "self clear", own_words[idx*DW +: DW], 32'h0);
    check_all(req);
  endtask

  task automatic host_read(logic [AW-1:0] addr, string req);
    int idx = int'(addr >> 2);
    bit err = addr_bad(addr) || (mode_of(idx) == 1);
    logic [31:0] exp = err ? 32'h0 : model[idx];
    s_araddr = addr; s_arvalid = 1'b1;
    while (!s_arready) @(negedge clk);
    @(negedge clk);
    s_arvalid = 1'b0;
    while (!s_rvalid) @(negedge clk);
    check(s_rresp == (err ? 2'b10 : 2'b00), req, "rresp", 32'(s_rresp), err ? 32'd2 : 32'd0);
    check(s_rdata == exp, req, "rdata", s_rdata, exp);
    @(negedge clk);
  endtask

  task automatic owner_write(int idx, logic [31:0] data);
    own_we = 1'b1; own_idx = idx[2:0]; own_wdata = data;
    @(negedge clk);
    own_we = 1'b0;
    model[idx] = data;
    check_all("R8");
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int op, order;
    logic [AW-1:0] a;
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < NW; i++) model[i] = '0;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!s_bvalid && !s_rvalid, "R1", "valids low", 32'({s_bvalid, s_rvalid}), 32'h0);
    check(wr_pulse == '0, "R1", "pulses low", 32'(wr_pulse), 32'h0);
    check_all("R1");

    // R2 two-word field, byte strobes, mixed channel order
    host_write(8'h00, 32'hA1B2C3D4, 4'hF, 0, 0, 0, "R2");
    host_write(8'h04, 32'h11223344, 4'b0101, 1, 0, 0, "R2");
    host_write(8'h00, 32'hFFFFFFFF, 4'b1000, 2, 0, 0, "R2");
    host_read(8'h00, "R2");
    host_read(8'h04, "R2");
    // R3 read-only write and write-only read
    owner_write(2, 32'hCAFEF00D);
    host_write(8'h08, 32'h0, 4'hF, 0, 0, 0, "R3");
    host_read(8'h08, "R3");
    host_write(8'h0C, 32'h5A5A5A5A, 4'hF, 0, 0, 0, "R3");
    host_read(8'h0C, "R3");
    // R4 misaligned and out of range
    host_write(8'h01, 32'hFFFFFFFF, 4'hF, 0, 0, 0, "R4");
    host_write(8'h20, 32'hFFFFFFFF, 4'hF, 0, 0, 0, "R4");
    host_read(8'h06, "R4");
    host_read(8'hFC, "R4");
    // R5 sticky status cleared by host
    owner_write(4, 32'hFFFF00FF);
    host_write(8'h10, 32'h0F0F0F0F, 4'b1101, 0, 0, 0, "R5");
    host_read(8'h10, "R5");
    // R6 trigger word
    host_write(8'h14, 32'h00000001, 4'hF, 0, 0, 0, "R6");
    host_read(8'h14, "R6");
    // R8 collision, owner wins
    host_write(8'h18, 32'h12345678, 4'hF, 0, 1, 32'h9999AAAA, "R8");
    // R9 back-pressure on B
    s_bready = 1'b0;
    host_write(8'h18, 32'h0BADBEEF, 4'hF, 2, 0, 0, "R9");

    for (int n = 0; n < 400; n++) begin
      op = int'($urandom % 8);
      order = int'($urandom % 3);
      case ($urandom % 10)
        0:       a = 8'($urandom);
        1:       a = 8'(32 + 4 * ($urandom % 56));
        default: a = 8'(4 * ($urandom % NW));
      endcase
      if (op < 4)      host_write(a, $urandom, 4'($urandom), order, 0, 0, "R2");
      else if (op < 7) host_read(a, "R2");
      else             owner_write(int'($urandom % NW), $urandom);
    end
    report();
  end
endmodule